// File: doc/BRIEF.md
# Frame Word Striping Distributor

This block sits behind a configuration port and takes a stream of 32-bit configuration words, one frame at a time. A frame holds 101 words. Two consecutive words go to each of 50 interconnect tile slots. One word, at index 50 in the middle of the frame, goes to a shared clock-row slot, and that word also holds the frame's error-correction bits. For every accepted word, the block raises exactly one write strobe, one cycle later. The strobe is either a one-hot tile strobe with the tile number and the word-within-tile index, or a clock-row strobe. The word itself appears on a shared write data bus.

Words enter through a valid/ready handshake. A word is taken on a rising clock edge when `in_valid` and `in_ready` are both high. `in_ready` is the inverse of the plain `sink_busy` input, so the tile slots hold the stream back by raising `sink_busy`. While a word is not taken, the sender must hold it. The word counter stays where it is, so no word is lost or repeated. `frame_start` marks the first word of a frame and only counts on an accepted beat. The block does not interpret the bits and never checks or acts on the error-correction field.

Top module: `frame_stripe_dist`

## Requirements
- R1: A frame is 101 accepted words. An accepted word with `frame_start` high is word 0, and each later accepted word takes the next index, up to 100.
- R2: Word i, for i from 0 to 49, writes tile i/2, with `tile_sel` equal to i mod 2.
- R3: Word 50 raises `row_we` and no tile strobe. Its data is passed unchanged, whatever its error-correction bits hold.
- R4: Word i, for i from 51 to 100, writes tile (i-1)/2, with `tile_sel` equal to (i-1) mod 2.
- R5: `frame_done` pulses for exactly one cycle, in the same cycle as the write of word 100. After that the block is outside any frame.
- R6: Each strobe, together with its `tile_idx`, `tile_sel` and `wr_data`, appears in the cycle after the word is accepted. At most one of the 51 strobes is high in any cycle.
- R7: `in_ready` equals the inverse of `sink_busy`. A cycle with no accepted word raises no strobe and does not advance the word index.
- R8: An accepted `frame_start` while a frame is still incomplete sets `short_err`. The flag stays set until reset, and the new word becomes word 0.
- R9: Words accepted outside a frame (after reset or after word 100, before the next `frame_start`) raise no strobe.
- R10: After reset, all strobes are low, `frame_done` is low, `short_err` is low, and the block is outside any frame.
- R11: A `frame_start` that follows a completed frame does not set `short_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Block can accept a word (inverse of sink_busy) |
| in_data | input | 32 | Configuration word |
| frame_start | input | 1 | Marks the accepted word as word 0 of a frame |
| sink_busy | input | 1 | Tile slots cannot take a word this cycle |
| tile_we | output | 50 | One-hot tile write strobes |
| tile_idx | output | 6 | Number of the tile being written |
| tile_sel | output | 1 | Word-within-tile index |
| row_we | output | 1 | Clock-row slot write strobe |
| wr_data | output | 32 | Data for the current strobe |
| frame_done | output | 1 | Pulses with the write of the last frame word |
| short_err | output | 1 | Sticky flag: a frame was restarted early |

## Verification
The assertions assume that `in_valid`, `frame_start` and `sink_busy` are driven synchronously and settle between clock edges, and that `frame_start` has no meaning on a beat that is not accepted. The stimulus changes inputs only on the falling edge. It mixes idle cycles, busy cycles, marker beats that are held back, stray words outside a frame and deliberately short frames. The reference model still sees every beat, so these cases stay inside the handshake rules.

// File: rtl/fsd_pkg.sv
package fsd_pkg;
  typedef enum logic [1:0] {
    SLOT_NONE = 2'd0,
    SLOT_TILE = 2'd1,
    SLOT_ROW  = 2'd2
  } slot_kind_e;
endpackage

// File: rtl/fsd_word_counter.sv
module fsd_word_counter #(
  parameter int FRAME_LEN = 101,
  parameter int IDX_W     = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic             frame_start,
  output logic [IDX_W-1:0] word_idx,
  output logic             word_live,
  output logic             last_word,
  output logic             short_err
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);

  logic [IDX_W-1:0] cnt_q;
  logic             in_frame_q;

  // index of the word on the input this cycle
  always_comb begin
    word_idx  = frame_start ? '0 : cnt_q;
    word_live = accept && (frame_start || in_frame_q);
    last_word = word_live && (word_idx == LAST_IDX);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      in_frame_q <= 1'b0;
      short_err  <= 1'b0;
    end else begin
      if (word_live) begin
        if (last_word) begin
          cnt_q      <= '0;
          in_frame_q <= 1'b0;
        end else begin
          cnt_q      <= word_idx + IDX_W'(1);
          in_frame_q <= 1'b1;
        end
      end
      if (accept && frame_start && in_frame_q) begin
        short_err <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/fsd_slot_map.sv
module fsd_slot_map
  import fsd_pkg::*;
#(
  parameter int TILE_CNT = 50,
  parameter int WPT      = 2,
  parameter int IDX_W    = 7,
  parameter int TILE_W   = 6,
  parameter int SEL_W    = 1
) (
  input  logic             word_live,
  input  logic [IDX_W-1:0] word_idx,
  output slot_kind_e       kind,
  output logic [TILE_W-1:0] tile,
  output logic [SEL_W-1:0] sel
);
  localparam int               ROW_POS_I = (TILE_CNT * WPT) / 2;
  localparam logic [IDX_W-1:0] ROW_POS   = IDX_W'(ROW_POS_I);
  localparam logic [IDX_W-1:0] WPT_C     = IDX_W'(WPT);

  logic [IDX_W-1:0] off;

  always_comb begin
    kind = SLOT_NONE;
    off  = word_idx;
    if (word_live) begin
      if (word_idx == ROW_POS) begin
        kind = SLOT_ROW;
      end else begin
        kind = SLOT_TILE;
        if (word_idx > ROW_POS) off = word_idx - IDX_W'(1);
      end
    end
    tile = TILE_W'(off / WPT_C);
    sel  = SEL_W'(off % WPT_C);
  end
endmodule

// File: rtl/fsd_out_stage.sv
module fsd_out_stage
  import fsd_pkg::*;
#(
  parameter int WORD_W   = 32,
  parameter int TILE_CNT = 50,
  parameter int TILE_W   = 6,
  parameter int SEL_W    = 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                accept,
  input  slot_kind_e          kind,
  input  logic [TILE_W-1:0]   tile,
  input  logic [SEL_W-1:0]    sel,
  input  logic [WORD_W-1:0]   data,
  input  logic                last_word,
  output logic [TILE_CNT-1:0] tile_we,
  output logic [TILE_W-1:0]   tile_idx,
  output logic [SEL_W-1:0]    tile_sel,
  output logic                row_we,
  output logic [WORD_W-1:0]   wr_data,
  output logic                frame_done
);
  slot_kind_e kind_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q     <= SLOT_NONE;
      tile_idx   <= '0;
      tile_sel   <= '0;
      wr_data    <= '0;
      frame_done <= 1'b0;
    end else begin
      kind_q     <= kind;
      frame_done <= last_word;
      if (accept) begin
        tile_idx <= tile;
        tile_sel <= sel;
        wr_data  <= data;
      end
    end
  end

  assign row_we = (kind_q == SLOT_ROW);

  for (genvar t = 0; t < TILE_CNT; t++) begin : g_we
    assign tile_we[t] = (kind_q == SLOT_TILE) && (tile_idx == TILE_W'(t));
  end
endmodule

// File: rtl/frame_stripe_dist.sv
module frame_stripe_dist
  import fsd_pkg::*;
#(
  parameter int WORD_W   = 32,
  parameter int TILE_CNT = 50,
  parameter int WPT      = 2,
  localparam int FRAME_LEN = TILE_CNT * WPT + 1,
  localparam int IDX_W     = $clog2(FRAME_LEN),
  localparam int TILE_W    = (TILE_CNT > 1) ? $clog2(TILE_CNT) : 1,
  localparam int SEL_W     = (WPT > 1) ? $clog2(WPT) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [WORD_W-1:0]   in_data,
  input  logic                frame_start,
  input  logic                sink_busy,
  output logic [TILE_CNT-1:0] tile_we,
  output logic [TILE_W-1:0]   tile_idx,
  output logic [SEL_W-1:0]    tile_sel,
  output logic                row_we,
  output logic [WORD_W-1:0]   wr_data,
  output logic                frame_done,
  output logic                short_err
);
  logic              accept;
  logic [IDX_W-1:0]  word_idx;
  logic              word_live;
  logic              last_word;
  slot_kind_e        kind;
  logic [TILE_W-1:0] tile;
  logic [SEL_W-1:0]  sel;

  assign in_ready = !sink_busy;
  assign accept   = in_valid && in_ready;

  fsd_word_counter #(.FRAME_LEN(FRAME_LEN), .IDX_W(IDX_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .accept(accept), .frame_start(frame_start),
    .word_idx(word_idx), .word_live(word_live), .last_word(last_word),
    .short_err(short_err)
  );

  fsd_slot_map #(.TILE_CNT(TILE_CNT), .WPT(WPT), .IDX_W(IDX_W),
                 .TILE_W(TILE_W), .SEL_W(SEL_W)) u_map (
    .word_live(word_live), .word_idx(word_idx),
    .kind(kind), .tile(tile), .sel(sel)
  );

  fsd_out_stage #(.WORD_W(WORD_W), .TILE_CNT(TILE_CNT), .TILE_W(TILE_W),
                  .SEL_W(SEL_W)) u_out (
    .clk(clk), .rst_n(rst_n), .accept(accept), .kind(kind), .tile(tile),
    .sel(sel), .data(in_data), .last_word(last_word),
    .tile_we(tile_we), .tile_idx(tile_idx), .tile_sel(tile_sel),
    .row_we(row_we), .wr_data(wr_data), .frame_done(frame_done)
  );
endmodule

// File: rtl/fsd_checker.sv
module fsd_checker #(
  parameter int TILE_CNT = 50,
  parameter int WPT      = 2,
  parameter int SEL_W    = 1
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic                in_ready,
  input logic                frame_start,
  input logic [TILE_CNT-1:0] tile_we,
  input logic [SEL_W-1:0]    tile_sel,
  input logic                row_we,
  input logic                frame_done,
  input logic                short_err
);
  p_one_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tile_we, row_we}));

  p_idle_no_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) |=> (tile_we == '0) && !row_we && !frame_done);

  p_done_last_slot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> tile_we[TILE_CNT-1] && (tile_sel == SEL_W'(WPT - 1)));

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    short_err |=> short_err);

  p_err_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(short_err) |-> $past(in_valid && in_ready && frame_start));
endmodule

bind frame_stripe_dist fsd_checker #(.TILE_CNT(TILE_CNT), .WPT(WPT), .SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .frame_start(frame_start), .tile_we(tile_we), .tile_sel(tile_sel),
  .row_we(row_we), .frame_done(frame_done), .short_err(short_err)
);

// File: tb/frame_stripe_dist_test.sv
`timescale 1ns/1ps
module frame_stripe_dist_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_data = '0;
  logic        frame_start = 1'b0;
  logic        sink_busy = 1'b0;
  logic [49:0] tile_we;
  logic [5:0]  tile_idx;
  logic [0:0]  tile_sel;
  logic        row_we;
  logic [31:0] wr_data;
  logic        frame_done;
  logic        short_err;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // reference model state
  bit m_in_frame = 0;
  int m_cnt = 0;
  bit m_err = 0;

  always #2.5 clk = ~clk;

  frame_stripe_dist uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .frame_start(frame_start), .sink_busy(sink_busy),
    .tile_we(tile_we), .tile_idx(tile_idx), .tile_sel(tile_sel),
    .row_we(row_we), .wr_data(wr_data), .frame_done(frame_done),
    .short_err(short_err)
  );

  function automatic void check(bit ok, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", what, act, exp, $time);
    end
  endfunction

  // tile number for a frame word index, -1 for the clock-row word
  function automatic int exp_tile(int idx);
    if (idx == 50) return -1;
    return (idx < 50) ? idx / 2 : (idx - 1) / 2;
  endfunction

  function automatic int exp_sel(int idx);
    return (idx < 50) ? idx % 2 : (idx - 1) % 2;
  endfunction

  // one cycle: drive at falling edge, check outputs at the next falling edge
  task automatic step(bit v, bit s, bit b, logic [31:0] d);
    int    idx = -1;
    bit    acc;
    bit    outside = 0;
    logic [49:0] ev = '0;
    bit    erow = 0, edone = 0;
    string mtag;
    in_valid = v; frame_start = s; sink_busy = b; in_data = d;
    #1;
    check(in_ready == !b, "R7 in_ready", in_ready, !b);
    acc = v && !b;
    if (acc) begin
      if (s) begin
        if (m_in_frame) m_err = 1;
        idx = 0;
      end else if (m_in_frame) idx = m_cnt;
      else outside = 1;
    end
    if (idx >= 0) begin
      if (exp_tile(idx) < 0) erow = 1;
      else ev = 50'd1 << exp_tile(idx);
      if (idx == 100) begin
        edone = 1; m_in_frame = 0; m_cnt = 0;
      end else begin
        m_in_frame = 1; m_cnt = idx + 1;
      end
    end
    @(posedge clk);
    @(negedge clk);
    mtag = (idx < 0) ? (outside ? "R9 no strobe outside frame" : "R7 no strobe when idle")
         : (idx == 50) ? "R3 row word" : (idx < 50) ? "R2 low half" : "R4 high half";
    check(tile_we == ev, {mtag, " R6 tile_we"}, tile_we, ev);
    check(row_we == erow, {mtag, " row_we"}, row_we, erow);
    check(frame_done == edone, "R1 R5 frame_done", frame_done, edone);
    check(short_err == m_err, "R8 R11 short_err", short_err, m_err);
    if (idx >= 0) begin
      check(wr_data == d, {mtag, " R6 wr_data"}, wr_data, d);
      if (!erow) begin
        check(tile_idx == 6'(exp_tile(idx)), {mtag, " tile_idx"}, tile_idx, exp_tile(idx));
        check(tile_sel == 1'(exp_sel(idx)), {mtag, " tile_sel"}, tile_sel, exp_sel(idx));
      end
    end
  endtask

  task automatic send_frame(int words, int gap_pct);
    for (int i = 0; i < words; i++) begin
      while (($urandom % 100) < gap_pct) begin
        if ($urandom % 2) step(1'b0, 1'($urandom % 2), 1'($urandom % 2), $urandom);
        else step(1'b1, (i == 0) ? 1'b1 : 1'($urandom % 2 == 0 && 0), 1'b1, $urandom);
      end
      step(1'b1, i == 0, 1'b0, $urandom);
    end
  endtask

  initial begin
    #(5ns * 150000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    // R10 reset state
    check(tile_we == '0, "R10 tile_we", tile_we, 0);
    check(row_we == 0, "R10 row_we", row_we, 0);
    check(frame_done == 0, "R10 frame_done", frame_done, 0);
    check(short_err == 0, "R10 short_err", short_err, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 stray words before any frame
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b0, $urandom);
    // R7 marker held back by busy has no effect
    step(1'b1, 1'b1, 1'b1, 32'hDEAD_0001);
    step(1'b1, 1'b0, 1'b0, 32'hDEAD_0002);
    // R1 R2 R3 R4 R5 back-to-back frame, row word carries arbitrary ECC bits
    for (int i = 0; i < 101; i++)
      step(1'b1, i == 0, 1'b0, (i == 50) ? 32'hFFFF_FFFF : 32'h1000_0000 + i);
    // R9 stray word after completion, R11 clean restart
    step(1'b1, 1'b0, 1'b0, 32'hBAD0_BAD0);
    send_frame(101, 0);
    // R7 frames with stalls and gaps
    send_frame(101, 40);
    send_frame(101, 25);
    // R8 short frame followed by a restart
    send_frame(37, 10);
    send_frame(101, 10);
    send_frame(51, 0);
    send_frame(101, 20);
    // random mix
    for (int f = 0; f < 30; f++) begin
      if (($urandom % 8) == 0) send_frame(1 + ($urandom % 100), 20);
      else send_frame(101, 30);
    end
    step(1'b0, 1'b0, 1'b0, '0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule